// File: doc/BRIEF.md
# Multiplexed External Data Bus Controller

This block serves the data-memory load and store requests of a small 8-bit processor core. Each request either lands in a small on-chip RAM in a single clock, or becomes a six-clock cycle on an external bus. On that bus the low byte of the address and the data byte share one port. An address latch enable marks the interval when that port holds the address. Separate active-low read and write strobes follow.

Two configuration bits and a two-bit size code decide where each access goes. The size code selects an on-chip RAM of 256, 512, 1024 or 2048 bytes. The external-select bit sends every access off chip. A page-access bit stops pointer accesses from driving the upper address port, so that port stays with its general-purpose I/O value.

An access uses one of two address forms. An 8-bit indirect access uses only the low address byte. A 16-bit pointer access uses the full address.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, rd_n and wr_n are high, ale is low, ad_oe is low and done is low.
- R2: With ext_sel low, an access that is indirect (ptr_mode=0), or a pointer access whose address is below 256 << size_code, goes on chip. done is high in the single cycle after the request edge, and ale, rd_n and wr_n stay inactive.
- R3: An on-chip write stores wdata. A later on-chip read of the same effective address returns that byte on rdata while done is high. An indirect access uses the effective address {8'h00, addr[7:0]}.
- R4: An external access occupies cycles 1 to 6 after the request edge. ale is high in cycle 1 only, and done is high in cycle 6 only.
- R5: In an external cycle, the strobe (rd_n for a read, wr_n for a write) is low in cycles 3, 4 and 5 only. The other strobe stays high, and both are never low together.
- R6: ad_oe is high with ad_out equal to the low effective address byte in cycles 1 and 2. For a write, ad_oe is high with ad_out equal to wdata in cycles 3 to 5. For a read, ad_oe is low from cycle 3. ad_oe is low in cycle 6.
- R7: An external read returns on rdata, in cycle 6, the byte present on ad_in at the end of cycle 5.
- R8: hi_port equals addr[15:8] in cycles 1 to 6 of an external pointer access while page_en is 0. In every other case it equals gpio_hi, including indirect external accesses and pointer accesses with page_en set.
- R9: With ext_sel high, every access, whether indirect or pointer and whatever its address, takes the external cycle.
- R10: A pointer access at or above 0x0800 always goes external, for any size_code and for either value of page_en.
- R11: A request raised while an external cycle is in progress is ignored: no further ale pulse and no further done pulse follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write byte |
| ptr_mode | input | 1 | 1 = 16-bit pointer, 0 = 8-bit indirect |
| size_code | input | 2 | On-chip RAM size: 256 << size_code bytes |
| ext_sel | input | 1 | Send every access to the external bus |
| page_en | input | 1 | Keep the upper port off pointer accesses |
| gpio_hi | input | 8 | General I/O value for the upper port |
| ad_in | input | 8 | Low port input (read data) |
| ad_out | output | 8 | Low port output (address or write data) |
| ad_oe | output | 1 | Low port drive enable; 0 = high impedance |
| hi_port | output | 8 | Upper port value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Read result, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives each request at a falling edge, so the design accepts it at the following rising edge. The check points are counted from that accepting edge:
- An on-chip access is due at the next falling edge, cycle 1, where done and rdata are checked.
- An external access is checked at every falling edge from cycle 1 to cycle 6. At each one the expected ale, strobe, port-enable, low-port and upper-port values for that cycle are compared.
- Read data is checked in cycle 6.
- The busy-request case is checked once more in cycle 7, for the absence of a second ale and done pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ALE, PH_HOLD, PH_S1, PH_S2, PH_S3, PH_END
    } xb_phase_t;

    typedef struct packed {
        xb_phase_t  ph;
        logic       ale;
        logic       rd_n;
        logic       wr_n;
        logic       ad_oe;
        logic [7:0] ad_out;
        logic       hi_own;
        logic [7:0] hi_addr;
        logic       is_wr;
        logic [7:0] wbyte;
        logic       done;
        logic [7:0] rdata;
    } xb_state_t;

endpackage

// File: rtl/xbus_route.sv
module xbus_route #(
    parameter int AW       = 16,
    parameter int BASE_AW  = 8,
    parameter int NSIZE    = 4
) (
    input  logic [AW-1:0]            addr,
    input  logic                     ptr_mode,
    input  logic [$clog2(NSIZE)-1:0] size_code,
    input  logic                     ext_sel,
    input  logic                     page_en,
    output logic [AW-1:0]            eff_addr,
    output logic                     to_eram,
    output logic                     own_hi
);
    logic [AW-1:0] limits [NSIZE];

    genvar g;
    generate
        for (g = 0; g < NSIZE; g++) begin : g_lim
            assign limits[g] = AW'(1) << (BASE_AW + g);
        end
    endgenerate

    always_comb begin
        eff_addr = ptr_mode ? addr : {{(AW-8){1'b0}}, addr[7:0]};
        to_eram  = !ext_sel && (eff_addr < limits[size_code]);
        own_hi   = ptr_mode && !page_en;
    end
endmodule

// File: rtl/xbus_eram.sv
module xbus_eram #(
    parameter int EAW = 11,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           we,
    input  logic [EAW-1:0] a,
    input  logic [DW-1:0]  wd,
    output logic [DW-1:0]  rd
);
    localparam int DEPTH = 1 << EAW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[a] <= wd;
    end

    assign rd = mem[a];
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int NSIZE = 4,
    localparam int SW   = $clog2(NSIZE),
    localparam int EAW  = 8 + NSIZE - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ptr_mode,
    input  logic [SW-1:0] size_code,
    input  logic          ext_sel,
    input  logic          page_en,
    input  logic [7:0]    gpio_hi,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [7:0]    hi_port,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] rdata,
    output logic          done
);
    xb_state_t st_q, st_d;

    logic [AW-1:0] eff_addr;
    logic          to_eram, own_hi;
    logic [DW-1:0] eram_rd;
    logic          eram_we;

    xbus_route #(.AW(AW), .BASE_AW(8), .NSIZE(NSIZE)) u_route (
        .addr(addr), .ptr_mode(ptr_mode), .size_code(size_code),
        .ext_sel(ext_sel), .page_en(page_en),
        .eff_addr(eff_addr), .to_eram(to_eram), .own_hi(own_hi)
    );

    assign eram_we = (st_q.ph == PH_IDLE) && req && we && to_eram;

    xbus_eram #(.EAW(EAW), .DW(DW)) u_eram (
        .clk(clk), .we(eram_we), .a(eff_addr[EAW-1:0]),
        .wd(wdata), .rd(eram_rd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req) begin
                    if (to_eram) begin
                        st_d.done = 1'b1;
                        if (!we) st_d.rdata = eram_rd;
                    end else begin
                        st_d.ph      = PH_ALE;
                        st_d.ale     = 1'b1;
                        st_d.ad_oe   = 1'b1;
                        st_d.ad_out  = eff_addr[7:0];
                        st_d.hi_own  = own_hi;
                        st_d.hi_addr = eff_addr[15:8];
                        st_d.is_wr   = we;
                        st_d.wbyte   = wdata;
                    end
                end
            end
            PH_ALE: begin
                st_d.ph  = PH_HOLD;
                st_d.ale = 1'b0;
            end
            PH_HOLD: begin
                st_d.ph = PH_S1;
                if (st_q.is_wr) begin
                    st_d.wr_n   = 1'b0;
                    st_d.ad_out = st_q.wbyte;
                end else begin
                    st_d.rd_n  = 1'b0;
                    st_d.ad_oe = 1'b0;
                end
            end
            PH_S1: st_d.ph = PH_S2;
            PH_S2: st_d.ph = PH_S3;
            PH_S3: begin
                st_d.ph    = PH_END;
                st_d.rd_n  = 1'b1;
                st_d.wr_n  = 1'b1;
                st_d.ad_oe = 1'b0;
                st_d.done  = 1'b1;
                if (!st_q.is_wr) st_d.rdata = ad_in;
            end
            PH_END: begin
                st_d.ph     = PH_IDLE;
                st_d.hi_own = 1'b0;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.rd_n <= 1'b1;
            st_q.wr_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ad_out  = st_q.ad_out;
    assign ad_oe   = st_q.ad_oe;
    assign ale     = st_q.ale;
    assign rd_n    = st_q.rd_n;
    assign wr_n    = st_q.wr_n;
    assign done    = st_q.done;
    assign rdata   = st_q.rdata;
    assign hi_port = st_q.hi_own ? st_q.hi_addr : gpio_hi;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic done
);
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (rd_n && wr_n && !ale && !ad_oe && !done));

    a_r5_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r7_done_at_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> done);
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .ad_oe(ad_oe), .done(done)
);

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, ptr_mode = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, gpio_hi = 8'h5A, ad_in = '0;
    logic [1:0]  size_code = '0;
    logic        ext_sel = 1'b0, page_en = 1'b0;
    logic [7:0]  ad_out, hi_port, rdata;
    logic        ad_oe, ale, rd_n, wr_n, done;

    int n_run = 0, n_fail = 0;
    logic [7:0] model [2048];

    always #2.5 clk = ~clk;

    xbus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ptr_mode(ptr_mode), .size_code(size_code),
        .ext_sel(ext_sel), .page_en(page_en), .gpio_hi(gpio_hi),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .hi_port(hi_port),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .done(done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic goes_onchip(logic p, logic [15:0] a, logic [1:0] sz, logic ex);
        logic [15:0] e = p ? a : {8'h00, a[7:0]};
        return !ex && (e < (16'd256 << sz));
    endfunction

    task automatic access(input logic w, input logic [15:0] a, input logic [7:0] d,
                          input logic p, input logic [1:0] sz, input logic ex,
                          input logic pg, input logic [7:0] rv, input logic busy_req);
        logic [15:0] e = p ? a : {8'h00, a[7:0]};
        logic onchip = goes_onchip(p, a, sz, ex);
        logic [7:0] gh = 8'(($urandom() & 8'hFF));
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; ptr_mode = p;
        size_code = sz; ext_sel = ex; page_en = pg; ad_in = rv; gpio_hi = gh;
        @(negedge clk);
        req = 1'b0;
        if (onchip) begin
            chk(done === 1'b1, "R2 onchip done", done, 1);
            chk(ale === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1, "R2 no bus activity",
                {ale, rd_n, wr_n}, 3'b011);
            if (w) model[e[10:0]] = d;
            else chk(rdata === model[e[10:0]], "R3 onchip read", rdata, model[e[10:0]]);
        end else begin
            for (int k = 1; k <= 6; k++) begin
                logic strobe = (k >= 3 && k <= 5);
                logic exp_oe = (k <= 2) || (w && strobe);
                logic [7:0] exp_ad = (k <= 2) ? e[7:0] : d;
                logic [7:0] exp_hi = (p && !pg) ? e[15:8] : gh;
                if (busy_req && k == 3) begin
                    req = 1'b1; addr = 16'h0001; ptr_mode = 1'b0; ext_sel = 1'b0;
                end
                if (busy_req && k == 4) req = 1'b0;
                chk(ale === (k == 1), "R4 ale timing", ale, (k == 1));
                chk(done === (k == 6), "R4 done timing", done, (k == 6));
                chk(rd_n === !(strobe && !w), "R5 rd_n", rd_n, !(strobe && !w));
                chk(wr_n === !(strobe && w), "R5 wr_n", wr_n, !(strobe && w));
                chk(ad_oe === exp_oe, "R6 ad_oe", ad_oe, exp_oe);
                if (exp_oe) chk(ad_out === exp_ad, "R6 ad_out", ad_out, exp_ad);
                chk(hi_port === exp_hi, "R8 hi_port", hi_port, exp_hi);
                if (k == 6 && !w) chk(rdata === rv, "R7 read data", rdata, rv);
                if (k < 6) @(negedge clk);
            end
            if (busy_req) begin
                req = 1'b0;
                @(negedge clk);
                chk(done === 1'b0 && ale === 1'b0, "R11 busy request ignored",
                    {done, ale}, 0);
            end
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++; n_run++;
                $display("FAIL watchdog: actual %0d expected <150000", cyc);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_n === 1 && wr_n === 1 && ale === 0 && ad_oe === 0 && done === 0,
            "R1 during reset", {rd_n, wr_n, ale, ad_oe, done}, 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_n === 1 && wr_n === 1 && ale === 0 && ad_oe === 0 && done === 0,
            "R1 after reset", {rd_n, wr_n, ale, ad_oe, done}, 5'b11000);

        // fill on-chip RAM through pointer accesses (R3)
        for (int i = 0; i < 2048; i++)
            access(1'b1, 16'(i), 8'(i * 7 + 3), 1'b1, 2'd3, 1'b0, 1'b0, 8'h00, 1'b0);

        // directed corners
        access(1'b0, 16'h07FF, 0, 1'b1, 2'd3, 1'b0, 1'b0, 8'h00, 1'b0); // R3 top on-chip
        access(1'b0, 16'hAB12, 0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0); // R3 indirect high byte ignored
        access(1'b0, 16'h0100, 0, 1'b1, 2'd0, 1'b0, 1'b0, 8'hC3, 1'b0); // R2 limit boundary -> ext
        access(1'b0, 16'h0800, 0, 1'b1, 2'd3, 1'b0, 1'b1, 8'h3C, 1'b0); // R10 page mode
        access(1'b1, 16'h0800, 8'h99, 1'b1, 2'd3, 1'b0, 1'b0, 8'h00, 1'b0); // R10
        access(1'b1, 16'h0010, 8'h66, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0); // R9 indirect ext
        access(1'b0, 16'h0020, 0, 1'b1, 2'd2, 1'b1, 1'b0, 8'hE1, 1'b0); // R9 pointer ext
        access(1'b0, 16'h1234, 0, 1'b1, 2'd1, 1'b0, 1'b0, 8'h7E, 1'b1); // R11 busy request
        access(1'b1, 16'h4321, 8'h18, 1'b1, 2'd1, 1'b0, 1'b0, 8'h00, 1'b1); // R11 on write

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a = ($urandom() % 4 == 0) ? 16'($urandom()) : 16'($urandom() % 16'h0C00);
            access(1'($urandom()), a, 8'($urandom()), 1'($urandom()), 2'($urandom()),
                   ($urandom() % 5 == 0), 1'($urandom()), 8'($urandom()),
                   ($urandom() % 10 == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule